// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block gathers interrupt requests from a parameterised set of peripheral sources and reduces them to a single candidate for the CPU. Each source has three parts:

- a sticky request flag, set by a one-cycle event pulse from that source;
- an enable bit;
- a control word holding a 3-bit priority level and a service-type bit.

A source with both its flag and its enable bit set is active. Among the active sources, the smallest level value wins. If several active sources share that level, the lowest source index wins.

The winner's number, level and service-type bit are held in registers and presented toward the CPU. A combinational accept signal compares the registered winner with the CPU's current mask level and global enable.

Control words are loaded through a single indexed write port. Each source index always maps to its own control word. A flag is cleared in either of two ways:

- a per-source clear strobe (the software write of zero);
- an acknowledge pulse that carries the source number.

Saving CPU state and fetching the vector are handled elsewhere.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A request flag becomes 1 on the clock edge at which its event input is 1. It then stays 1 until a clear or acknowledge for that source takes effect. The flags are visible on `pend_o`, bit i for source i.
- R2: A clear strobe `clr_i[i]` clears flag i at the next edge. An acknowledge (`ack_i`=1 with `ack_num_i`=i) also clears flag i at the next edge. Neither affects any other flag.
- R3: If an event and a clear or acknowledge for the same source occur in the same cycle, the flag ends up 1.
- R4: Only sources with both flag and enable set take part. If no source is active, `win_valid_o` is 0.
- R5: Among active sources, the winner is the one with the numerically smallest level.
- R6: Among active sources tied at the smallest level, the lowest source index wins.
- R7: `take_o` is 1 only when all three hold:
  - `win_valid_o` is 1;
  - `win_lvl_o` is strictly less than `cpu_ilm_i`;
  - `cpu_ie_i` is 1.
  `take_o` follows `cpu_ilm_i` and `cpu_ie_i` in the same cycle.
- R8: A winner at level 7 is never accepted, whatever the mask.
- R9: `win_svc_o` carries the service-type bit of the winning source's control word. A value of 0 means ordinary interrupt service.
- R10: The winner outputs (`win_valid_o`, `win_num_o`, `win_lvl_o`, `win_svc_o`) are registered. They reflect the flags and control words present one edge earlier. An event is therefore seen on the winner outputs two edges after it is applied.
- R11: After reset the following hold:
  - every flag is 0 and every winner output is 0;
  - every control word is level 7, disabled, service bit 0.
- R12: A write with `cfg_wr_i`=1 loads `cfg_en_i`, `cfg_lvl_i` and `cfg_svc_i` into the control word of source `cfg_sel_i` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_SRC | Per-source event pulses |
| clr_i | input | N_SRC | Per-source flag clear strobes |
| ack_i | input | 1 | Acknowledge strobe |
| ack_num_i | input | NUM_W | Source number being acknowledged |
| cfg_wr_i | input | 1 | Control word write strobe |
| cfg_sel_i | input | NUM_W | Source index for the write |
| cfg_en_i | input | 1 | Enable bit to write |
| cfg_lvl_i | input | 3 | Level to write |
| cfg_svc_i | input | 1 | Service-type bit to write |
| cpu_ilm_i | input | 3 | CPU mask level |
| cpu_ie_i | input | 1 | CPU global interrupt enable |
| pend_o | output | N_SRC | Request flags |
| win_valid_o | output | 1 | A winner exists |
| win_num_o | output | NUM_W | Winning source index |
| win_lvl_o | output | 3 | Winning level |
| win_svc_o | output | 1 | Winning service-type bit |
| take_o | output | 1 | CPU may accept the winner |

## Verification
A corrupted flag appears on `pend_o` one edge after the bad stimulus. It reaches the winner outputs one edge later, but only if the source is enabled and at the best level.

A wrong control word stays hidden until its source becomes active. At that point it shows up as a wrong winner number, level or service bit, or as a flip of `take_o`.

The bench compares every output against a behavioural model on every clock. A wrong state is therefore reported in the first cycle in which it becomes visible.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_OFF = '1;

  typedef struct packed {
    logic en;
    logic svc;
    lvl_t lvl;
  } src_cfg_t;

  localparam src_cfg_t CFG_RST = '{en: 1'b0, svc: 1'b0, lvl: LVL_OFF};
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N_SRC = 16,
  localparam int NUM_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic             ack_i,
  input  logic [NUM_W-1:0] ack_num_i,
  output logic [N_SRC-1:0] flag_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    logic ack_hit;
    assign ack_hit = ack_i && (ack_num_i == NUM_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[i] <= 1'b0;
      else if (evt_i[i]) flag_o[i] <= 1'b1;  // set beats clear
      else if (clr_i[i] || ack_hit) flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
  import irq_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int NUM_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [NUM_W-1:0] sel_i,
  input  src_cfg_t         wdata_i,
  output src_cfg_t         cfg_o [N_SRC]
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_o[i] <= CFG_RST;
      else if (wr_i && sel_i == NUM_W'(i)) cfg_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int NUM_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] act_i,
  input  src_cfg_t         cfg_i [N_SRC],
  output logic             hit_o,
  output logic [NUM_W-1:0] num_o,
  output lvl_t             lvl_o,
  output logic             svc_o
);
  // ascending scan, strict compare keeps the lowest index on ties
  always_comb begin
    hit_o = 1'b0;
    num_o = '0;
    lvl_o = LVL_OFF;
    svc_o = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (act_i[i] && (!hit_o || cfg_i[i].lvl < lvl_o)) begin
        hit_o = 1'b1;
        num_o = NUM_W'(i);
        lvl_o = cfg_i[i].lvl;
        svc_o = cfg_i[i].svc;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int NUM_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic             ack_i,
  input  logic [NUM_W-1:0] ack_num_i,
  input  logic             cfg_wr_i,
  input  logic [NUM_W-1:0] cfg_sel_i,
  input  logic             cfg_en_i,
  input  logic [2:0]       cfg_lvl_i,
  input  logic             cfg_svc_i,
  input  logic [2:0]       cpu_ilm_i,
  input  logic             cpu_ie_i,
  output logic [N_SRC-1:0] pend_o,
  output logic             win_valid_o,
  output logic [NUM_W-1:0] win_num_o,
  output logic [2:0]       win_lvl_o,
  output logic             win_svc_o,
  output logic             take_o
);
  src_cfg_t         cfg_q [N_SRC];
  src_cfg_t         wdata;
  logic [N_SRC-1:0] act;
  logic             arb_hit;
  logic [NUM_W-1:0] arb_num;
  lvl_t             arb_lvl;
  logic             arb_svc;

  assign wdata = '{en: cfg_en_i, svc: cfg_svc_i, lvl: cfg_lvl_i};

  irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
    .clk_i, .rst_ni, .evt_i, .clr_i, .ack_i, .ack_num_i, .flag_o(pend_o)
  );

  irq_cfg_bank #(.N_SRC(N_SRC)) u_cfg (
    .clk_i, .rst_ni, .wr_i(cfg_wr_i), .sel_i(cfg_sel_i), .wdata_i(wdata), .cfg_o(cfg_q)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_act
    assign act[i] = pend_o[i] & cfg_q[i].en;
  end

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .act_i(act), .cfg_i(cfg_q), .hit_o(arb_hit), .num_o(arb_num),
    .lvl_o(arb_lvl), .svc_o(arb_svc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_valid_o <= 1'b0;
      win_num_o   <= '0;
      win_lvl_o   <= '0;
      win_svc_o   <= 1'b0;
    end else begin
      win_valid_o <= arb_hit;
      win_num_o   <= arb_num;
      win_lvl_o   <= arb_hit ? arb_lvl : '0;
      win_svc_o   <= arb_hit & arb_svc;
    end
  end

  assign take_o = win_valid_o && cpu_ie_i && (win_lvl_o < cpu_ilm_i);
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_SRC = 16,
  localparam int NUM_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] evt_i,
  input logic [N_SRC-1:0] clr_i,
  input logic             ack_i,
  input logic [NUM_W-1:0] ack_num_i,
  input logic             cpu_ie_i,
  input logic [N_SRC-1:0] pend_o,
  input logic [N_SRC-1:0] act,
  input logic             win_valid_o,
  input logic [NUM_W-1:0] win_num_o,
  input logic [2:0]       win_lvl_o,
  input logic             take_o
);
  logic [N_SRC-1:0] act_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_d <= '0;
    else         act_d <= act;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    // R3
    evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> pend_o[i]);
    // R1
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_o[i] && !clr_i[i] && !(ack_i && ack_num_i == NUM_W'(i)) |=> pend_o[i]);
  end

  // R4
  idle_no_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|act_d) |-> !win_valid_o);
  // R10
  win_was_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> act_d[win_num_o]);
  // R8
  lvl_off_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_lvl_o == 3'd7) |-> !take_o);
  // R7
  ie_low_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_ie_i |-> !take_o);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i, .rst_ni, .evt_i, .clr_i, .ack_i, .ack_num_i, .cpu_ie_i,
  .pend_o, .act, .win_valid_o, .win_num_o, .win_lvl_o, .take_o
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int N = 16;
  localparam int NW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] evt_i = '0, clr_i = '0;
  logic ack_i = 1'b0;
  logic [NW-1:0] ack_num_i = '0;
  logic cfg_wr_i = 1'b0;
  logic [NW-1:0] cfg_sel_i = '0;
  logic cfg_en_i = 1'b0, cfg_svc_i = 1'b0;
  logic [2:0] cfg_lvl_i = '0;
  logic [2:0] cpu_ilm_i = 3'd7;
  logic cpu_ie_i = 1'b1;
  logic [N-1:0] pend_o;
  logic win_valid_o, win_svc_o, take_o;
  logic [NW-1:0] win_num_o;
  logic [2:0] win_lvl_o;

  always #2 clk_i = ~clk_i;  // 250 MHz

  irq_prio_ctrl #(.N_SRC(N)) uut (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int m_flag[N], m_en[N], m_lvl[N], m_svc[N];
  int e_valid = 0, e_num = 0, e_lvl = 0, e_svc = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_win();
    e_valid = 0; e_num = 0; e_lvl = 0; e_svc = 0;
    for (int i = 0; i < N; i++)
      if (m_flag[i] != 0 && m_en[i] != 0 && (e_valid == 0 || m_lvl[i] < e_lvl)) begin
        e_valid = 1; e_num = i; e_lvl = m_lvl[i]; e_svc = m_svc[i];
      end
  endtask

  task automatic compare(string tag);
    logic [N-1:0] ep;
    int et;
    for (int i = 0; i < N; i++) ep[i] = (m_flag[i] != 0);
    chk("R1 R2 R3 pend", pend_o, ep);
    chk({tag, " valid"}, win_valid_o, e_valid);
    chk({tag, " num"}, win_num_o, e_num);
    chk({tag, " lvl"}, win_lvl_o, e_lvl);
    chk("R9 svc", win_svc_o, e_svc);
    et = (e_valid != 0 && cpu_ie_i && e_lvl < int'(cpu_ilm_i)) ? 1 : 0;
    chk("R7 R8 take", take_o, et);
  endtask

  // one clock: inputs driven at negedge, model advanced at posedge
  task automatic step(string tag, logic [N-1:0] ev, logic [N-1:0] cl, logic ak, int an,
                      logic wr, int sel, logic en, int lvl, logic svc, int ilm, logic ie);
    @(negedge clk_i);
    evt_i = ev; clr_i = cl; ack_i = ak; ack_num_i = NW'(an);
    cfg_wr_i = wr; cfg_sel_i = NW'(sel); cfg_en_i = en; cfg_lvl_i = 3'(lvl); cfg_svc_i = svc;
    cpu_ilm_i = 3'(ilm); cpu_ie_i = ie;
    @(posedge clk_i);
    model_win();
    for (int i = 0; i < N; i++) begin
      if (ev[i]) m_flag[i] = 1;
      else if (cl[i] || (ak && an == i)) m_flag[i] = 0;
    end
    if (wr) begin m_en[sel] = en; m_lvl[sel] = lvl; m_svc[sel] = svc; end
    #1 compare(tag);
  endtask

  task automatic cfg(int sel, int lvl, logic en, logic svc);
    step("R12", '0, '0, 0, 0, 1, sel, en, lvl, svc, 7, 1);
  endtask

  task automatic idle(string tag, int ilm, logic ie);
    step(tag, '0, '0, 0, 0, 0, 0, 0, 0, 0, ilm, ie);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_flag[i] = 0; m_en[i] = 0; m_lvl[i] = 7; m_svc[i] = 0; end
    #1;
    chk("R11 pend", pend_o, 0);
    chk("R11 valid", win_valid_o, 0);
    #10 rst_ni = 1'b1;
    idle("R11", 7, 1);
    // R4: event on disabled source (reset config) -> no winner
    step("R4", 16'h0010, '0, 0, 0, 0, 0, 0, 0, 0, 7, 1);
    idle("R4", 7, 1);
    idle("R4", 7, 1);
    // enable and configure
    cfg(4, 5, 1, 0);
    idle("R10", 7, 1);
    cfg(9, 2, 1, 1);
    cfg(3, 2, 1, 0);
    cfg(12, 7, 1, 0);
    // R10: event on src 9, winner seen two edges later
    step("R10", 16'h0200, '0, 0, 0, 0, 0, 0, 0, 0, 7, 1);
    idle("R10", 7, 1);
    idle("R5", 3, 1);
    // R6: src3 ties at level 2, lower index wins
    step("R6", 16'h0008, '0, 0, 0, 0, 0, 0, 0, 0, 2, 1);
    idle("R6", 2, 1);
    idle("R7", 3, 0);
    // R2: acknowledge src3, then clear src9
    step("R2", '0, '0, 1, 3, 0, 0, 0, 0, 0, 7, 1);
    idle("R2", 7, 1);
    step("R2", '0, 16'h0200, 0, 0, 0, 0, 0, 0, 0, 7, 1);
    idle("R5", 7, 1);
    // R3: event and clear same cycle
    step("R3", 16'h0010, 16'h0010, 1, 4, 0, 0, 0, 0, 0, 7, 1);
    idle("R3", 7, 1);
    // R8: only level-7 source left
    step("R8", '0, 16'h0010, 0, 0, 0, 0, 0, 0, 0, 7, 1);
    step("R8", 16'h1000, '0, 0, 0, 0, 0, 0, 0, 0, 7, 1);
    idle("R8", 7, 1);
    idle("R8", 7, 1);
    // random traffic
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] ev, cl;
      ev = N'($urandom) & N'($urandom) & N'($urandom);
      cl = N'($urandom) & N'($urandom);
      step("R5 R6", ev, cl, 1'($urandom), int'($urandom % N),
           ($urandom % 4) == 0, int'($urandom % N), 1'($urandom % 4 != 0),
           int'($urandom % 8), 1'($urandom), int'($urandom % 8), 1'($urandom % 4 != 0));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule